// File: doc/BRIEF.md
# Ordered Commit Store Buffer

This block holds the stores of a speculative core between allocation and their write to memory. Each store is split into two operations that reach the buffer separately and in either order. One carries the target address and access size, the other the write data. Both halves are written by index into the entry that was reserved for the store when it was allocated. An entry may leave for memory only once both halves are present and retirement has committed it. Entries leave strictly in allocation order, one at a time, from the oldest entry.

A flush, used when a branch resolves the wrong way, discards the uncommitted stores from a given entry to the youngest. A committed store survives every flush. A load-conflict query compares a load against every store older than that load and reports whether the load must wait. It reports a conflict when the byte ranges overlap, and also when an older store's address is not yet known. The caller states the load's age as the allocation pointer value seen when the load was issued.

Top module: `stq_top`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_ptr` is 0, `mem_req_valid` is 0 and `ld_conflict` is 0.
- R2: `alloc_ptr` holds a lap bit at bit IDXW above an entry index in the low IDXW bits. Each accepted allocation advances it by one. The index wraps from DEPTH-1 to 0 and the lap bit toggles on the wrap. With DEPTH entries in use, `alloc_ready` is 0 and a request to allocate changes nothing.
- R3: The address half and the data half of a store may arrive in either order. The memory request presents the address, size and data that were written into that entry.
- R4: `mem_req_valid` is 1 only when the oldest entry is committed and holds both halves. It is 0 when the buffer is empty.
- R5: Stores reach memory in allocation order. An allocation and an acknowledged write in the same cycle both take effect.
- R6: An unacknowledged request keeps its address and data unchanged. An acknowledgement removes the oldest entry.
- R7: Each `commit_valid` pulse commits the oldest uncommitted entry. A pulse with no uncommitted entry is ignored and does not commit a later allocation.
- R8: A flush at an index that names an allocated, uncommitted entry sets the allocation pointer back to that entry, so it and all younger entries are discarded. A flush naming a committed or unallocated entry is ignored. In a flush cycle, allocation and commit are ignored.
- R9: A load is reported as conflicting when any store older than the load has no address yet.
- R10: A load is reported as conflicting when its byte range overlaps the byte range of an older store with a known address. A size code s covers 2^s bytes: 0 is 1 byte, 1 is 2, 2 is 4 and 3 is 8.
- R11: Only stores allocated before the load count. These are the entries from the oldest up to, but not including, `ld_bound`. Younger stores never cause a conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Reserve an entry for a new store |
| alloc_ready | output | 1 | An entry is free |
| alloc_ptr | output | IDXW+1 | Lap bit and index of the next entry to be allocated |
| aw_valid | input | 1 | Address half arrives |
| aw_idx | input | IDXW | Entry the address half belongs to |
| aw_addr | input | AW | Store address |
| aw_size | input | 2 | Size code, 2^code bytes |
| dw_valid | input | 1 | Data half arrives |
| dw_idx | input | IDXW | Entry the data half belongs to |
| dw_data | input | DW | Store data |
| commit_valid | input | 1 | Commit the oldest uncommitted entry |
| flush_valid | input | 1 | Discard uncommitted entries |
| flush_idx | input | IDXW | Oldest entry to discard |
| mem_req_valid | output | 1 | Oldest entry is ready for memory |
| mem_req_addr | output | AW | Request address |
| mem_req_size | output | 2 | Request size code |
| mem_req_data | output | DW | Request data |
| mem_req_ack | input | 1 | Memory accepts the request |
| ld_bound | input | IDXW+1 | Allocation pointer value seen when the load issued |
| ld_addr | input | AW | Load address |
| ld_size | input | 2 | Load size code |
| ld_conflict | output | 1 | Load must wait for an older store |

## Verification
Allocation and draining can fall in the same cycle, and that is the collision the bench targets. It first fills the buffer, which proves that allocation is refused when full. It then drains one store to leave a single free entry. Next it raises `alloc_valid` together with `mem_req_ack` on a valid request. The bench then expects all of the following at once: `alloc_ptr` one step further, `alloc_ready` still 1, and the request showing the next store in order. The remaining drains must follow allocation order. The fresh entry must stay idle until it is committed.

// File: rtl/stq_pkg.sv
package stq_pkg;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;

  // distance from pointer b forward to pointer a on a ring with lap bits
  function automatic int ring_dist(input int a_idx, input logic a_lap,
                                   input int b_idx, input logic b_lap,
                                   input int depth);
    if (a_lap == b_lap) return a_idx - b_idx;
    return a_idx + depth - b_idx;
  endfunction

  // true when [a, a+2^sa) and [b, b+2^sb) share a byte
  function automatic logic spans_overlap(input logic [63:0] a, input logic [1:0] sa,
                                         input logic [63:0] b, input logic [1:0] sb);
    logic [64:0] a_end;
    logic [64:0] b_end;
    a_end = {1'b0, a} + (65'd1 << sa);
    b_end = {1'b0, b} + (65'd1 << sb);
    return ({1'b0, a} < b_end) && ({1'b0, b} < a_end);
  endfunction

endpackage

// File: rtl/stq_ptrs.sv
module stq_ptrs
  import stq_pkg::*;
#(
  parameter  int DEPTH = 12,
  localparam int IDXW  = $clog2(DEPTH),
  localparam int PW    = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_en,
  input  logic            pop_en,
  input  logic            commit_en,
  input  logic            flush_en,
  input  logic [IDXW-1:0] flush_idx,
  output logic [PW-1:0]   head_q,
  output logic [PW-1:0]   cmt_q,
  output logic [PW-1:0]   tail_q,
  output logic [IDXW:0]   used,
  output logic [IDXW:0]   ncmt
);

  localparam int CW = IDXW + 1;

  logic [PW-1:0] head_n, cmt_n, tail_n, flush_tail;
  logic          flush_ok;
  int            fdist;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    if (int'(p[IDXW-1:0]) == DEPTH - 1) return {~p[IDXW], {IDXW{1'b0}}};
    return {p[IDXW], p[IDXW-1:0] + 1'b1};
  endfunction

  assign used = CW'(ring_dist(int'(tail_q[IDXW-1:0]), tail_q[IDXW],
                              int'(head_q[IDXW-1:0]), head_q[IDXW], DEPTH));
  assign ncmt = CW'(ring_dist(int'(cmt_q[IDXW-1:0]), cmt_q[IDXW],
                              int'(head_q[IDXW-1:0]), head_q[IDXW], DEPTH));

  always_comb begin
    if (flush_idx >= head_q[IDXW-1:0]) begin
      fdist      = int'(flush_idx) - int'(head_q[IDXW-1:0]);
      flush_tail = {head_q[IDXW], flush_idx};
    end else begin
      fdist      = int'(flush_idx) + DEPTH - int'(head_q[IDXW-1:0]);
      flush_tail = {~head_q[IDXW], flush_idx};
    end
    flush_ok = flush_en && (fdist >= int'(ncmt)) && (fdist < int'(used));
  end

  always_comb begin
    head_n = pop_en ? ptr_inc(head_q) : head_q;
    cmt_n  = (commit_en && !flush_en && (ncmt < used)) ? ptr_inc(cmt_q) : cmt_q;
    if (flush_ok)      tail_n = flush_tail;
    else if (alloc_en) tail_n = ptr_inc(tail_q);
    else               tail_n = tail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      cmt_q  <= cmt_n;
      tail_q <= tail_n;
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used) <= DEPTH)
    else $error("occupancy above depth");

  p_commit_within_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ncmt <= used)
    else $error("commit pointer passed allocation pointer");

  p_flush_spares_committed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && !pop_en) |=> (ncmt == $past(ncmt)))
    else $error("flush changed committed entries");

endmodule

// File: rtl/stq_conflict.sv
module stq_conflict
  import stq_pkg::*;
#(
  parameter  int DEPTH = 12,
  parameter  int AW    = 16,
  localparam int IDXW  = $clog2(DEPTH),
  localparam int PW    = IDXW + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PW-1:0]              head_q,
  input  logic [IDXW:0]              used,
  input  logic [PW-1:0]              ld_bound,
  input  logic [AW-1:0]              ld_addr,
  input  logic [1:0]                 ld_size,
  input  logic [DEPTH-1:0]           a_known,
  input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
  input  logic [DEPTH-1:0][1:0]      ent_size,
  output logic                       ld_conflict
);

  int n_old;
  int raw;

  always_comb begin
    raw = ring_dist(int'(ld_bound[IDXW-1:0]), ld_bound[IDXW],
                    int'(head_q[IDXW-1:0]), head_q[IDXW], DEPTH);
    n_old = ((raw < 0) || (raw > int'(used))) ? 0 : raw;
    ld_conflict = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      int kd;
      kd = (k >= int'(head_q[IDXW-1:0])) ? k - int'(head_q[IDXW-1:0])
                                         : k + DEPTH - int'(head_q[IDXW-1:0]);
      if ((kd < n_old) &&
          (!a_known[k] ||
           spans_overlap(64'(ent_addr[k]), ent_size[k], 64'(ld_addr), ld_size)))
        ld_conflict = 1'b1;
    end
  end

  p_empty_no_conflict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (used == '0) |-> !ld_conflict)
    else $error("conflict reported against an empty buffer");

endmodule

// File: rtl/stq_top.sv
module stq_top
  import stq_pkg::*;
#(
  parameter  int DEPTH = 12,
  parameter  int AW    = 16,
  parameter  int DW    = 32,
  localparam int IDXW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  output logic            alloc_ready,
  output logic [IDXW:0]   alloc_ptr,
  input  logic            aw_valid,
  input  logic [IDXW-1:0] aw_idx,
  input  logic [AW-1:0]   aw_addr,
  input  logic [1:0]      aw_size,
  input  logic            dw_valid,
  input  logic [IDXW-1:0] dw_idx,
  input  logic [DW-1:0]   dw_data,
  input  logic            commit_valid,
  input  logic            flush_valid,
  input  logic [IDXW-1:0] flush_idx,
  output logic            mem_req_valid,
  output logic [AW-1:0]   mem_req_addr,
  output logic [1:0]      mem_req_size,
  output logic [DW-1:0]   mem_req_data,
  input  logic            mem_req_ack,
  input  logic [IDXW:0]   ld_bound,
  input  logic [AW-1:0]   ld_addr,
  input  logic [1:0]      ld_size,
  output logic            ld_conflict
);

  localparam int PW = IDXW + 1;

  logic [PW-1:0]             head_q, cmt_q, tail_q;
  logic [IDXW:0]             used, ncmt;
  logic                      alloc_fire, pop_fire;
  logic [DEPTH-1:0]          a_known, d_known;
  logic [DEPTH-1:0][AW-1:0]  ent_addr;
  logic [DEPTH-1:0][1:0]     ent_size;
  logic [DEPTH-1:0][DW-1:0]  ent_data;
  logic [IDXW-1:0]           head_idx;

  assign alloc_ready = (int'(used) < DEPTH);
  assign alloc_fire  = alloc_valid && alloc_ready && !flush_valid;
  assign alloc_ptr   = tail_q;
  assign head_idx    = head_q[IDXW-1:0];

  stq_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_fire),
    .pop_en    (pop_fire),
    .commit_en (commit_valid),
    .flush_en  (flush_valid),
    .flush_idx (flush_idx),
    .head_q    (head_q),
    .cmt_q     (cmt_q),
    .tail_q    (tail_q),
    .used      (used),
    .ncmt      (ncmt)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic          hit_alloc, hit_aw, hit_dw;
    logic          ak_q, dk_q;
    logic [AW-1:0] addr_q;
    logic [1:0]    size_q;
    logic [DW-1:0] data_q;

    assign hit_alloc = alloc_fire && (tail_q[IDXW-1:0] == IDXW'(g));
    assign hit_aw    = aw_valid && (aw_idx == IDXW'(g)) && !hit_alloc;
    assign hit_dw    = dw_valid && (dw_idx == IDXW'(g)) && !hit_alloc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ak_q <= 1'b0;
        dk_q <= 1'b0;
      end else begin
        if (hit_alloc)   ak_q <= 1'b0;
        else if (hit_aw) ak_q <= 1'b1;
        if (hit_alloc)   dk_q <= 1'b0;
        else if (hit_dw) dk_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_aw) begin
        addr_q <= aw_addr;
        size_q <= aw_size;
      end
      if (hit_dw) data_q <= dw_data;
    end

    assign a_known[g]  = ak_q;
    assign d_known[g]  = dk_q;
    assign ent_addr[g] = addr_q;
    assign ent_size[g] = size_q;
    assign ent_data[g] = data_q;
  end

  assign mem_req_valid = (ncmt != '0) && a_known[head_idx] && d_known[head_idx];
  assign mem_req_addr  = ent_addr[head_idx];
  assign mem_req_size  = ent_size[head_idx];
  assign mem_req_data  = ent_data[head_idx];
  assign pop_fire      = mem_req_valid && mem_req_ack;

  stq_conflict #(.DEPTH(DEPTH), .AW(AW)) conflict_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .head_q      (head_q),
    .used        (used),
    .ld_bound    (ld_bound),
    .ld_addr     (ld_addr),
    .ld_size     (ld_size),
    .a_known     (a_known),
    .ent_addr    (ent_addr),
    .ent_size    (ent_size),
    .ld_conflict (ld_conflict)
  );

  p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ack) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)))
    else $error("pending request changed before acknowledgement");

  p_empty_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (used == '0) |-> !mem_req_valid)
    else $error("request raised with an empty buffer");

endmodule

// File: tb/stq_top_tb_top.sv
module stq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 12;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int IDXW  = 4;
  localparam int PW    = IDXW + 1;

  logic            clk;
  logic            rst_n;
  logic            alloc_valid;
  logic            alloc_ready;
  logic [IDXW:0]   alloc_ptr;
  logic            aw_valid;
  logic [IDXW-1:0] aw_idx;
  logic [AW-1:0]   aw_addr;
  logic [1:0]      aw_size;
  logic            dw_valid;
  logic [IDXW-1:0] dw_idx;
  logic [DW-1:0]   dw_data;
  logic            commit_valid;
  logic            flush_valid;
  logic [IDXW-1:0] flush_idx;
  logic            mem_req_valid;
  logic [AW-1:0]   mem_req_addr;
  logic [1:0]      mem_req_size;
  logic [DW-1:0]   mem_req_data;
  logic            mem_req_ack;
  logic [IDXW:0]   ld_bound;
  logic [AW-1:0]   ld_addr;
  logic [1:0]      ld_size;
  logic            ld_conflict;

  int  n_checks = 0;
  int  n_errors = 0;
  int  nseq     = 0;
  bit  done     = 0;

  stq_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_ptr(alloc_ptr),
    .aw_valid(aw_valid), .aw_idx(aw_idx), .aw_addr(aw_addr), .aw_size(aw_size),
    .dw_valid(dw_valid), .dw_idx(dw_idx), .dw_data(dw_data),
    .commit_valid(commit_valid), .flush_valid(flush_valid), .flush_idx(flush_idx),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_data(mem_req_data), .mem_req_ack(mem_req_ack),
    .ld_bound(ld_bound), .ld_addr(ld_addr), .ld_size(ld_size), .ld_conflict(ld_conflict)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic logic [PW-1:0] exp_ptr(input int n);
    int m;
    m = n % (2 * DEPTH);
    return (m >= DEPTH) ? PW'((1 << IDXW) + (m - DEPTH)) : PW'(m);
  endfunction

  function automatic logic [IDXW-1:0] idx_of(input int n);
    return IDXW'(n % DEPTH);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_alloc();
    chk("R2 alloc pointer", alloc_ptr, exp_ptr(nseq));
    alloc_valid = 1'b1;
    tick();
    alloc_valid = 1'b0;
    nseq++;
  endtask

  task automatic wb_addr(input logic [IDXW-1:0] i, input logic [AW-1:0] a, input logic [1:0] s);
    aw_valid = 1'b1; aw_idx = i; aw_addr = a; aw_size = s;
    tick();
    aw_valid = 1'b0;
  endtask

  task automatic wb_data(input logic [IDXW-1:0] i, input logic [DW-1:0] d);
    dw_valid = 1'b1; dw_idx = i; dw_data = d;
    tick();
    dw_valid = 1'b0;
  endtask

  task automatic commit1();
    commit_valid = 1'b1;
    tick();
    commit_valid = 1'b0;
  endtask

  task automatic flush_at(input logic [IDXW-1:0] i, input bit with_alloc);
    flush_valid = 1'b1; flush_idx = i; alloc_valid = with_alloc;
    tick();
    flush_valid = 1'b0; alloc_valid = 1'b0;
  endtask

  task automatic drain_expect(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w;
    w = 0;
    while (!mem_req_valid && w < 20) begin
      tick();
      w++;
    end
    chk({req, " request valid"}, mem_req_valid, 1'b1);
    chk({req, " request address"}, mem_req_addr, a);
    chk({req, " request data"}, mem_req_data, d);
    mem_req_ack = 1'b1;
    tick();
    mem_req_ack = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int base;
    int sidx_n;
    logic [PW-1:0] s_ptr;
    rst_n = 1'b0;
    alloc_valid = 0; aw_valid = 0; aw_idx = 0; aw_addr = 0; aw_size = 0;
    dw_valid = 0; dw_idx = 0; dw_data = 0; commit_valid = 0; flush_valid = 0;
    flush_idx = 0; mem_req_ack = 0; ld_bound = 0; ld_addr = 0; ld_size = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 alloc_ready", alloc_ready, 1'b1);
    chk("R1 alloc_ptr", alloc_ptr, 0);
    chk("R1 mem_req_valid", mem_req_valid, 1'b0);
    chk("R1 ld_conflict", ld_conflict, 1'b0);

    // R3 R4 R6: halves in either order, commit gating
    do_alloc(); do_alloc(); do_alloc();
    wb_data(4'd1, 32'hD1);
    wb_addr(4'd0, 16'h0040, 2'd2);
    wb_addr(4'd1, 16'h0080, 2'd1);
    wb_data(4'd0, 32'hD0);
    wb_data(4'd2, 32'hD2);
    chk("R4 uncommitted head stays idle", mem_req_valid, 1'b0);
    commit1();
    chk("R3 head valid", mem_req_valid, 1'b1);
    chk("R3 head address", mem_req_addr, 16'h0040);
    chk("R3 head size", mem_req_size, 2'd2);
    chk("R3 head data", mem_req_data, 32'hD0);
    tick(); tick();
    chk("R6 held valid", mem_req_valid, 1'b1);
    chk("R6 held address", mem_req_addr, 16'h0040);
    mem_req_ack = 1'b1; tick(); mem_req_ack = 1'b0;
    chk("R4 next head uncommitted", mem_req_valid, 1'b0);
    commit1(); commit1();
    chk("R3 data-first entry address", mem_req_addr, 16'h0080);
    chk("R3 data-first entry data", mem_req_data, 32'hD1);
    chk("R3 data-first entry size", mem_req_size, 2'd1);
    mem_req_ack = 1'b1; tick(); mem_req_ack = 1'b0;
    chk("R4 head without address idle", mem_req_valid, 1'b0);
    wb_addr(4'd2, 16'h00C0, 2'd0);
    drain_expect("R5 third store", 16'h00C0, 32'hD2);
    chk("R4 empty no request", mem_req_valid, 1'b0);

    // R2 fill to depth with wrap
    for (int k = 0; k < DEPTH; k++) do_alloc();
    chk("R2 full alloc_ready", alloc_ready, 1'b0);
    alloc_valid = 1'b1; tick(); alloc_valid = 1'b0;
    chk("R2 alloc ignored when full", alloc_ptr, exp_ptr(nseq));
    for (int k = 0; k < DEPTH; k++) begin
      wb_addr(idx_of(3 + k), AW'(16'h0200 + 4 * k), 2'd2);
      wb_data(idx_of(3 + k), DW'(32'h1000 + k));
    end
    for (int k = 0; k < DEPTH + 1; k++) commit1();   // R7 one surplus pulse
    drain_expect("R5 full drain 0", 16'h0200, 32'h1000);
    // R5 allocation and drain in the same cycle
    chk("R5 second store before collision", mem_req_addr, 16'h0204);
    alloc_valid = 1'b1; mem_req_ack = 1'b1;
    tick();
    alloc_valid = 1'b0; mem_req_ack = 1'b0;
    nseq++;
    chk("R5 alloc_ready after collision", alloc_ready, 1'b1);
    chk("R5 alloc_ptr after collision", alloc_ptr, exp_ptr(nseq));
    chk("R5 head after collision", mem_req_addr, 16'h0208);
    for (int k = 2; k < DEPTH; k++)
      drain_expect("R5 ordered drain", AW'(16'h0200 + 4 * k), DW'(32'h1000 + k));
    chk("R7 fresh entry idle", mem_req_valid, 1'b0);
    wb_addr(idx_of(nseq - 1), 16'h02F0, 2'd3);
    wb_data(idx_of(nseq - 1), 32'h2F0);
    chk("R7 surplus commit not applied", mem_req_valid, 1'b0);
    commit1();
    drain_expect("R7 committed fresh entry", 16'h02F0, 32'h2F0);

    // R8 flush
    base = nseq;
    for (int k = 0; k < 4; k++) do_alloc();
    commit1();
    flush_at(idx_of(base), 1'b0);
    chk("R8 flush of committed ignored", alloc_ptr, exp_ptr(nseq));
    flush_at(idx_of(base + 5), 1'b0);
    chk("R8 flush of unallocated ignored", alloc_ptr, exp_ptr(nseq));
    flush_at(idx_of(base + 2), 1'b0);
    nseq = base + 2;
    chk("R8 flush rewinds", alloc_ptr, exp_ptr(nseq));
    flush_at(idx_of(base + 1), 1'b1);
    nseq = base + 1;
    chk("R8 flush wins over alloc", alloc_ptr, exp_ptr(nseq));
    wb_addr(idx_of(base), 16'h0300, 2'd2);
    wb_data(idx_of(base), 32'hAAAA);
    drain_expect("R8 committed survivor", 16'h0300, 32'hAAAA);
    chk("R8 nothing left", mem_req_valid, 1'b0);
    chk("R8 alloc_ready", alloc_ready, 1'b1);
    do_alloc();
    wb_addr(idx_of(nseq - 1), 16'h0310, 2'd0);
    wb_data(idx_of(nseq - 1), 32'hBBBB);
    commit1();
    drain_expect("R8 reused entry", 16'h0310, 32'hBBBB);

    // R9 R10 R11 load conflict
    s_ptr  = exp_ptr(nseq);
    sidx_n = nseq;
    do_alloc();
    ld_bound = exp_ptr(nseq); ld_addr = 16'h0500; ld_size = 2'd0;
    #1;
    chk("R9 older unknown address", ld_conflict, 1'b1);
    ld_bound = s_ptr;
    #1;
    chk("R11 store younger than load", ld_conflict, 1'b0);
    for (int sb = 0; sb < 4; sb++) begin
      wb_addr(idx_of(sidx_n), 16'h0100, 2'(sb));
      ld_bound = s_ptr; ld_addr = 16'h0100; ld_size = 2'd2;
      #1;
      chk("R11 overlapping younger store ignored", ld_conflict, 1'b0);
      for (int la = 16'h00F8; la < 16'h0110; la++) begin
        for (int ls = 0; ls < 4; ls++) begin
          bit e;
          ld_bound = exp_ptr(nseq); ld_addr = AW'(la); ld_size = 2'(ls);
          #1;
          e = (la < 16'h0100 + (1 << sb)) && (16'h0100 < la + (1 << ls));
          chk("R10 overlap", ld_conflict, e);
        end
      end
    end
    flush_at(idx_of(sidx_n), 1'b0);
    nseq = sidx_n;
    ld_bound = exp_ptr(nseq + 1);
    #1;
    chk("R8 flushed store gone from query", ld_conflict, 1'b0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule